// File: doc/BRIEF.md
# Chained Retriggerable Watchdog Counter Bank

This block holds four 64-bit down-counters behind a small register interface. Each counter has a control word and a 64-bit count, which software writes and reads as two 32-bit halves. A counter runs in one of two modes. In one-shot mode, setting its enable bit starts a countdown from the loaded value. In hardware-retrigger mode, the counter reloads and restarts whenever the counter just below it signals end-count.

A 4-bit select register marks which counters act as the watchdog. When a selected counter reaches zero, the block drives a reset pulse of fixed length. The usual setup chains two counters. The lower counter is a one-shot loaded with zero. The upper counter is in retrigger mode and is selected as the watchdog. Toggling the lower counter's enable bit makes it signal end-count at once, which reloads the watchdog counter. The watchdog counter is never stopped during this keepalive.

Top module: `wdtCounterBank`

## Requirements
- R1: Register map. Counter n's control word is at byte offset n*0x10. Its count low word is at +0x4 and its count high word at +0x8. The select register is at 0x40 and uses bits 3:0. The control word has enable at bit 0, a read-only active flag at bit 1, mode at bits 3:2, trigger source at bits 7:4 and prescaler at bits 15:8. All other bits read 0. Read data appears the cycle after `rdEn`.
- R2: A write to a count word sets that half of both the counter's reload value and its current count.
- R3: Mode 00 is one-shot, and any mode other than 11 behaves the same way. A 0-to-1 change of the enable bit loads the count from the reload value. The count then drops by one every P clocks and stops at 0, where the active flag clears.
- R4: Enabling a one-shot counter whose reload value is 0 raises its end-count event in the next cycle and leaves the counter inactive.
- R5: P equals the prescaler field, except that a field value of 0 or 1 gives P = 2.
- R6: Mode 11 with trigger source 0x5 is hardware retrigger. When the counter is enabled, the end-count of counter n-1 reloads it and starts it counting. Counter 0 takes counter 3 as its predecessor. An enabled retrigger counter that receives no trigger stays inactive and keeps its count.
- R7: Turning the helper one-shot counter off and back on restarts the chained counter from its reload value, without the chained counter ever being disabled.
- R8: Reading a count low word captures bits 63:32 of that count. A later read of the high word returns the captured bits, not the live ones.
- R9: Clearing the enable bit stops counting and clears the active flag in the same cycle. The stored count is kept.
- R10: When a counter whose select bit is set reaches end-count, `wdogReset` goes high in the following cycle and stays high for RESET_CYCLES cycles (16 by default). End-count on a counter that is not selected has no effect on `wdogReset`.
- R11: After reset, every register reads 0 and `wdogReset` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rdEn |
| wdogReset | output | 1 | Watchdog reset pulse |

## Verification
The hardest case to reach is the chained keepalive. Keeping the watchdog counter alive needs a steady run of off/on writes to the helper counter, each timed so that the watchdog counter never reaches zero. When the pings stop, the bench must find the exact cycle in which the reset starts. The bench runs a chain of keepalives about 16 cycles apart, and it counts the expected expiry cycle from the last enable write. It also checks the latched high word by reading the count halves while a borrow crosses bit 32. The one-shot countdown is tested with random reload values, prescalers and sampling delays. Those results are compared against a closed-form model in the bench.

// File: rtl/wdtBankPkg.sv
package wdtBankPkg;
  localparam int NUM_CNT = 4;
  localparam int CNT_W = 64;
  localparam int WORD_W = 32;
  localparam int PSC_W = 8;
  localparam int IDX_W = $clog2(NUM_CNT);
  localparam logic [3:0] TRIG_PREV = 4'h5;
  localparam logic [1:0] MODE_HWSIG = 2'b11;
  localparam logic [7:0] SEL_ADDR = 8'h40;

  typedef struct packed {
    logic [PSC_W-1:0] presc;
    logic [3:0] trig;
    logic [1:0] mode;
    logic en;
  } ctrlT;

  typedef struct packed {
    logic [NUM_CNT-1:0] wrCtrl;
    logic [NUM_CNT-1:0] wrLow;
    logic [NUM_CNT-1:0] wrHigh;
    logic [NUM_CNT-1:0] rdLow;
    logic [WORD_W-1:0] wdata;
  } strobeT;
endpackage

// File: rtl/wdtCounterSlice.sv
module wdtCounterSlice
  import wdtBankPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic wrCtrl,
  input  logic wrLow,
  input  logic wrHigh,
  input  logic rdLow,
  input  logic [WORD_W-1:0] wdata,
  input  logic prevEnd,
  output ctrlT ctrlQ,
  output logic [WORD_W-1:0] countLoQ,
  output logic [WORD_W-1:0] holdQ,
  output logic activeQ,
  output logic endQ
);
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] reloadQ;
  logic [PSC_W-1:0] pscCnt;
  logic [PSC_W-1:0] pscLimit;
  ctrlT newCtrl;
  logic startOneShot;
  logic hwTrig;
  logic reloadZero;

  always_comb begin
    newCtrl.en = wdata[0];
    newCtrl.mode = wdata[3:2];
    newCtrl.trig = wdata[7:4];
    newCtrl.presc = wdata[15:8];
  end

  // Division ratio: fields below 2 are forced to 2.
  assign pscLimit = (ctrlQ.presc < PSC_W'(2)) ? PSC_W'(1) : ctrlQ.presc - PSC_W'(1);
  assign startOneShot = wrCtrl && newCtrl.en && !ctrlQ.en && (newCtrl.mode != MODE_HWSIG);
  assign hwTrig = ctrlQ.en && (ctrlQ.mode == MODE_HWSIG) && (ctrlQ.trig == TRIG_PREV) && prevEnd;
  assign reloadZero = (reloadQ == '0);
  assign countLoQ = countQ[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      countQ <= '0;
      reloadQ <= '0;
      pscCnt <= '0;
      holdQ <= '0;
      activeQ <= 1'b0;
      endQ <= 1'b0;
    end else begin
      endQ <= 1'b0;
      if (wrCtrl) ctrlQ <= newCtrl;
      if (rdLow) holdQ <= countQ[CNT_W-1:WORD_W];
      if (wrCtrl && !newCtrl.en) begin
        activeQ <= 1'b0;
      end else if (startOneShot || hwTrig) begin
        countQ <= reloadQ;
        pscCnt <= '0;
        activeQ <= !reloadZero;
        endQ <= reloadZero;
      end else if (activeQ && ctrlQ.en) begin
        if (pscCnt == pscLimit) begin
          pscCnt <= '0;
          if (countQ <= CNT_W'(1)) begin
            countQ <= '0;
            activeQ <= 1'b0;
            endQ <= 1'b1;
          end else begin
            countQ <= countQ - CNT_W'(1);
          end
        end else begin
          pscCnt <= pscCnt + PSC_W'(1);
        end
      end
      if (wrLow) begin
        reloadQ[WORD_W-1:0] <= wdata;
        countQ[WORD_W-1:0] <= wdata;
      end
      if (wrHigh) begin
        reloadQ[CNT_W-1:WORD_W] <= wdata;
        countQ[CNT_W-1:WORD_W] <= wdata;
      end
    end
  end
endmodule

// File: rtl/wdtBankDatapath.sv
module wdtBankDatapath
  import wdtBankPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  strobeT strb,
  output ctrlT [NUM_CNT-1:0] ctrlQ,
  output logic [NUM_CNT-1:0][WORD_W-1:0] countLo,
  output logic [NUM_CNT-1:0][WORD_W-1:0] holdHi,
  output logic [NUM_CNT-1:0] activeQ,
  output logic [NUM_CNT-1:0] endCount
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : gSlice
    localparam int PREV = (i + NUM_CNT - 1) % NUM_CNT;
    wdtCounterSlice sliceI (
      .clk(clk),
      .rstN(rstN),
      .wrCtrl(strb.wrCtrl[i]),
      .wrLow(strb.wrLow[i]),
      .wrHigh(strb.wrHigh[i]),
      .rdLow(strb.rdLow[i]),
      .wdata(strb.wdata),
      .prevEnd(endCount[PREV]),
      .ctrlQ(ctrlQ[i]),
      .countLoQ(countLo[i]),
      .holdQ(holdHi[i]),
      .activeQ(activeQ[i]),
      .endQ(endCount[i])
    );
  end
endmodule

// File: rtl/wdtBankCtrl.sv
module wdtBankCtrl
  import wdtBankPkg::*;
#(
  parameter int RESET_CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic rdEn,
  input  logic [7:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output strobeT strb,
  input  ctrlT [NUM_CNT-1:0] ctrlQ,
  input  logic [NUM_CNT-1:0][WORD_W-1:0] countLo,
  input  logic [NUM_CNT-1:0][WORD_W-1:0] holdHi,
  input  logic [NUM_CNT-1:0] activeQ,
  input  logic [NUM_CNT-1:0] endCount,
  output logic [NUM_CNT-1:0] selQ,
  output logic wdogReset
);
  localparam int RST_W = $clog2(RESET_CYCLES + 1);

  logic isCnt;
  logic isSel;
  logic [IDX_W-1:0] idx;
  logic [1:0] sub;
  logic [RST_W-1:0] rstCnt;
  logic fire;

  assign isCnt = (addr[7:6] == 2'b00) && (addr[1:0] == 2'b00);
  assign isSel = (addr == SEL_ADDR);
  assign idx = addr[4 +: IDX_W];
  assign sub = addr[3:2];

  always_comb begin
    strb = '0;
    strb.wdata = wdata;
    if (isCnt && wrEn) begin
      case (sub)
        2'd0: strb.wrCtrl[idx] = 1'b1;
        2'd1: strb.wrLow[idx] = 1'b1;
        2'd2: strb.wrHigh[idx] = 1'b1;
        default: ;
      endcase
    end
    if (isCnt && rdEn && sub == 2'd1) strb.rdLow[idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata <= '0;
      selQ <= '0;
    end else begin
      if (wrEn && isSel) selQ <= wdata[NUM_CNT-1:0];
      if (rdEn) begin
        rdata <= '0;
        if (isSel) begin
          rdata <= WORD_W'(selQ);
        end else if (isCnt) begin
          case (sub)
            2'd0: rdata <= WORD_W'({ctrlQ[idx].presc, ctrlQ[idx].trig, ctrlQ[idx].mode,
                                    activeQ[idx], ctrlQ[idx].en});
            2'd1: rdata <= countLo[idx];
            2'd2: rdata <= holdHi[idx];
            default: rdata <= '0;
          endcase
        end
      end
    end
  end

  assign fire = |(endCount & selQ);

  always_ff @(posedge clk) begin
    if (!rstN) rstCnt <= '0;
    else if (fire) rstCnt <= RST_W'(RESET_CYCLES);
    else if (rstCnt != '0) rstCnt <= rstCnt - RST_W'(1);
  end

  assign wdogReset = (rstCnt != '0);
endmodule

// File: rtl/wdtCounterBank.sv
module wdtCounterBank
  import wdtBankPkg::*;
#(
  parameter int RESET_CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic rdEn,
  input  logic [7:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic wdogReset
);
  strobeT strb;
  ctrlT [NUM_CNT-1:0] ctrlQ;
  logic [NUM_CNT-1:0][WORD_W-1:0] countLo;
  logic [NUM_CNT-1:0][WORD_W-1:0] holdHi;
  logic [NUM_CNT-1:0] activeQ;
  logic [NUM_CNT-1:0] endCount;
  logic [NUM_CNT-1:0] selQ;
  logic [NUM_CNT-1:0] enBits;

  for (genvar i = 0; i < NUM_CNT; i++) begin : gEn
    assign enBits[i] = ctrlQ[i].en;
  end

  wdtBankCtrl #(.RESET_CYCLES(RESET_CYCLES)) ctrlI (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .strb(strb), .ctrlQ(ctrlQ), .countLo(countLo), .holdHi(holdHi),
    .activeQ(activeQ), .endCount(endCount), .selQ(selQ), .wdogReset(wdogReset)
  );

  wdtBankDatapath dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .ctrlQ(ctrlQ), .countLo(countLo),
    .holdHi(holdHi), .activeQ(activeQ), .endCount(endCount)
  );
endmodule

// File: rtl/wdtBankChecker.sv
module wdtBankChecker #(
  parameter int N = 4,
  parameter int RESET_CYCLES = 16
) (
  input logic clk,
  input logic rstN,
  input logic wdogReset,
  input logic [N-1:0] endCount,
  input logic [N-1:0] selQ,
  input logic [N-1:0] activeQ,
  input logic [N-1:0] enBits
);
  logic [31:0] hiCnt;

  always_ff @(posedge clk) begin
    if (!rstN) hiCnt <= '0;
    else if (wdogReset) hiCnt <= (hiCnt == 32'hFFFF_FFFF) ? hiCnt : hiCnt + 32'd1;
    else hiCnt <= '0;
  end

  AST_RESET_FROM_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdogReset) |-> $past(|(endCount & selQ))); // R10
  AST_RESET_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdogReset) |-> (hiCnt >= 32'(RESET_CYCLES))); // R10
  AST_END_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (endCount & activeQ) == '0); // R3
  AST_ACTIVE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ & ~enBits) == '0); // R9
endmodule

bind wdtCounterBank wdtBankChecker #(.N(wdtBankPkg::NUM_CNT), .RESET_CYCLES(RESET_CYCLES)) chkI (
  .clk(clk), .rstN(rstN), .wdogReset(wdogReset), .endCount(endCount),
  .selQ(selQ), .activeQ(activeQ), .enBits(enBits)
);

// File: tb/wdtCounterBank_tb_top.sv
module wdtCounterBank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RST_LEN = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic wdogReset;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdtCounterBank #(.RESET_CYCLES(RST_LEN)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wdogReset(wdogReset)
  );

  function automatic logic [7:0] aCtrl(int n); return 8'(n * 16); endfunction
  function automatic logic [7:0] aLow(int n); return 8'(n * 16 + 4); endfunction
  function automatic logic [7:0] aHigh(int n); return 8'(n * 16 + 8); endfunction
  function automatic int effDiv(int p); return (p < 2) ? 2 : p; endfunction
  function automatic int oneShotLeft(int r, int p, int k);
    int v;
    v = r - k / effDiv(p);
    return (v < 0) ? 0 : v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All bus tasks are entered and left at a falling edge.
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdata;
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int seedInit;
    bit quiet;
    seedInit = $urandom(32'd24681);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(wdogReset == 1'b0, "R11 reset output", 32'(wdogReset), 0);
    busRead(aCtrl(1), rd); check(rd == 0, "R11 ctrl1 after reset", rd, 0);
    busRead(8'h40, rd); check(rd == 0, "R11 select after reset", rd, 0);

    // R1 field layout and read-only bits
    busWrite(aCtrl(2), 32'hFFFF_125E);
    busRead(aCtrl(2), rd); check(rd == 32'h0000_125C, "R1 ctrl readback", rd, 32'h125C);
    busWrite(8'h40, 32'hFF);
    busRead(8'h40, rd); check(rd == 32'hF, "R1 select width", rd, 32'hF);
    busWrite(8'h40, 0);
    busWrite(aCtrl(2), 0);

    // R2 count halves
    busWrite(aLow(3), 32'hDEAD_BEEF);
    busWrite(aHigh(3), 32'h1234_5678);
    busRead(aLow(3), rd); check(rd == 32'hDEAD_BEEF, "R2 low word", rd, 32'hDEAD_BEEF);
    busRead(aHigh(3), rd); check(rd == 32'h1234_5678, "R2 high word", rd, 32'h1234_5678);

    // R3 / R5 random one-shot countdown on counter 2
    for (int it = 0; it < 20; it++) begin
      int r, p, k;
      r = 1 + int'($urandom % 40);
      p = int'($urandom % 7);
      k = int'($urandom % 32'(r * effDiv(p) + 6));
      busWrite(aCtrl(2), 0);
      busWrite(aLow(2), 32'(r));
      busWrite(aHigh(2), 0);
      busWrite(aCtrl(2), {16'h0, 8'(p), 8'h01});
      waitNeg(k);
      busRead(aLow(2), rd);
      check(rd == 32'(oneShotLeft(r, p, k)), (p < 2) ? "R5 forced divide" : "R3 countdown",
            rd, 32'(oneShotLeft(r, p, k)));
      busRead(aCtrl(2), rd);
      check(rd[1] == (oneShotLeft(r, p, k + 1) > 0), "R3 active flag",
            32'(rd[1]), 32'(oneShotLeft(r, p, k + 1) > 0));
    end
    busWrite(aCtrl(2), 0);

    // R8 latched high word across a borrow through bit 32
    busWrite(aCtrl(3), 0);
    busWrite(aLow(3), 1);
    busWrite(aHigh(3), 1);
    busWrite(aCtrl(3), 32'h0201);
    waitNeg(3);
    busRead(aLow(3), rd); check(rd == 0, "R8 low before borrow", rd, 0);
    busRead(aHigh(3), rd); check(rd == 1, "R8 captured high", rd, 1);
    busRead(aLow(3), rd); check(rd == 32'hFFFF_FFFF, "R8 low after borrow", rd, 32'hFFFF_FFFF);
    busRead(aHigh(3), rd); check(rd == 0, "R8 high after borrow", rd, 0);
    busWrite(aCtrl(3), 0);

    // R9 disable keeps count
    busWrite(aLow(2), 100);
    busWrite(aHigh(2), 0);
    busWrite(aCtrl(2), 32'h0201);
    waitNeg(9);
    busWrite(aCtrl(2), 32'h0200);
    busRead(aLow(2), rd); check(rd == 96, "R9 count held at disable", rd, 96);
    waitNeg(10);
    busRead(aLow(2), rd); check(rd == 96, "R9 count stays", rd, 96);
    busRead(aCtrl(2), rd); check(rd == 32'h0200, "R9 active cleared", rd, 32'h0200);

    // R6 retrigger counter idles with no trigger
    busWrite(aLow(1), 10);
    busWrite(aHigh(1), 0);
    busWrite(aCtrl(1), 32'h025D);
    waitNeg(20);
    busRead(aLow(1), rd); check(rd == 10, "R6 idle count", rd, 10);
    busRead(aCtrl(1), rd); check(rd == 32'h025D, "R6 idle inactive", rd, 32'h025D);

    // R4 / R6 / R10 chained start and expiry
    busWrite(8'h40, 32'h2);
    busWrite(aCtrl(0), 32'h0201);
    waitNeg(4);
    busRead(aLow(1), rd); check(rd == 9, "R4 R6 chained start", rd, 9);
    busRead(aCtrl(0), rd); check(rd[1] == 1'b0, "R4 helper inactive", 32'(rd[1]), 0);
    waitNeg(15);
    check(wdogReset == 1'b0, "R10 no reset before expiry", 32'(wdogReset), 0);
    waitNeg(1); check(wdogReset == 1'b1, "R10 reset starts", 32'(wdogReset), 1);
    waitNeg(15); check(wdogReset == 1'b1, "R10 reset last cycle", 32'(wdogReset), 1);
    waitNeg(1); check(wdogReset == 1'b0, "R10 reset ends", 32'(wdogReset), 0);

    // R7 keepalive chain
    for (int pg = 0; pg < 6; pg++) begin
      busWrite(aCtrl(0), 32'h0200);
      busWrite(aCtrl(0), 32'h0201);
      if (pg == 0) begin
        waitNeg(5);
        busRead(aLow(1), rd); check(rd == 8, "R7 reload after ping", rd, 8);
        waitNeg(8);
      end else begin
        quiet = 1'b1;
        for (int w = 0; w < 14; w++) begin
          @(negedge clk);
          if (wdogReset) quiet = 1'b0;
        end
        check(quiet, "R7 no reset while pinged", 32'(!quiet), 0);
      end
    end
    waitNeg(7);
    check(wdogReset == 1'b0, "R7 held off by last ping", 32'(wdogReset), 0);
    waitNeg(1); check(wdogReset == 1'b1, "R7 expiry after pings stop", 32'(wdogReset), 1);
    waitNeg(20);

    // R10 unselected expiry
    busWrite(8'h40, 0);
    busWrite(aCtrl(0), 32'h0200);
    busWrite(aCtrl(0), 32'h0201);
    quiet = 1'b1;
    for (int w = 0; w < 40; w++) begin
      @(negedge clk);
      if (wdogReset) quiet = 1'b0;
    end
    check(quiet, "R10 unselected expiry ignored", 32'(!quiet), 0);
    busRead(aLow(1), rd); check(rd == 0, "R10 unselected counter expired", rd, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule